// File: doc/BRIEF.md
# Sync-Tip Clamp Pulse Generator

This block produces the timing pulse that a video decoder uses to clamp the sync tip of the incoming signal. Each rising edge of the sync-detect strobe arms a delay counter. When the delay has run out, the block raises the clamp pulse and holds it for a set number of clocks. The delay and the width each come from a 3-bit code in an 8-bit control register. The width codes follow a nonlinear table. The design runs on the pixel clock of about 27 MHz, so one clock lasts roughly 37 ns.

The same register holds a 2-bit selector for an external clamp pin. The selector picks one of four things for the pin:
- high impedance,
- the internal sync-tip pulse,
- a pedestal clamp pulse that arrives from outside the block,
- the raw sync-detect signal.

The pin appears as a data output with a separate active-high output enable. The block carries no data stream, so it has no valid/ready interface and no back-pressure. Every pin is a plain control or status level.

Top module: `tipclamp_gen`

## Requirements
- R1: After reset the register reads 0x11. This gives start code 001 (4 clocks), width code 010 (8 clocks) and pin select 00. The clamp pulse is low and the pin enable is low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the register, and `cfg_rdata` shows the new value after that edge. Without `cfg_we` the register holds its value. Bits 2:0 are the start code, bits 5:3 are the width code and bits 7:6 are the pin select.
- R3: If `sync_det` is first sampled high at edge k while it was low at the edge before, `tip_pulse` rises after edge k+D. Here D = 2×(start code+1), which gives 2 to 16 clocks.
- R4: The pulse stays high for exactly W clocks and then goes low. Width codes 0 to 7 give W = 2, 4, 8, 16, 24, 32, 40 and 48.
- R5: A sync rising edge that arrives during the delay or during the pulse is ignored. It neither restarts the delay nor adds a second pulse.
- R6: The delay and width are captured at the accepted sync edge. A register write during a delay or a pulse does not change that pulse. The new value applies from the next sync edge.
- R7: With select 00, `pin_oe` is 0 and `pin_out` is 0.
- R8: With select 01, `pin_oe` is 1 and `pin_out` equals `tip_pulse`.
- R9: With select 10, `pin_oe` is 1 and `pin_out` equals `ped_clamp`.
- R10: With select 11, `pin_oe` is 1 and `pin_out` equals `sync_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Single-cycle register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register value |
| sync_det | input | 1 | Horizontal sync-detect strobe |
| ped_clamp | input | 1 | Pedestal clamp pulse from outside the block |
| tip_pulse | output | 1 | Internal sync-tip clamp pulse |
| pin_out | output | 1 | Data driven toward the external clamp pin |
| pin_oe | output | 1 | Active-high enable for the external clamp pin |

## Verification
The bench goes after the ends of the width table: the 2-clock and 48-clock codes, and the step between the doubling codes and the linear codes. A decoder that got this table wrong would produce pulses that are off by a multiple of 8. It also sends a second sync edge into the middle of a delay and into the middle of a pulse. A design that retriggers would show two rising edges, or a late or stretched pulse. It rewrites the register in the middle of a pulse. A design that decodes the live register instead of a captured copy would cut that pulse short, while the pulse that follows must already use the new codes. Every measurement window also checks the pin against the select, which catches a swapped selector or an enable left on in the high-impedance setting.

// File: rtl/tipclamp_pkg.sv
`timescale 1ns/1ps
package tipclamp_pkg;

  // Largest count the timer holds (the widest pulse is 48 clocks)
  localparam int MAX_CLKS = 48;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam int CODE_W   = 3;

  typedef enum logic [1:0] {
    PIN_HIZ  = 2'b00,
    PIN_TIP  = 2'b01,
    PIN_PED  = 2'b10,
    PIN_SYNC = 2'b11
  } pin_sel_e;

  // Field positions match the register bit layout
  typedef struct packed {
    pin_sel_e          sel;    // 7:6
    logic [CODE_W-1:0] width;  // 5:3
    logic [CODE_W-1:0] start;  // 2:0
  } clamp_cfg_t;

  typedef enum logic [1:0] {
    TMR_IDLE = 2'b00,
    TMR_WAIT = 2'b01,
    TMR_HOLD = 2'b10
  } tmr_state_e;

  // Start delay: 2*(code+1) clocks
  function automatic logic [CNT_W-1:0] start_clks(input logic [CODE_W-1:0] c);
    return (CNT_W'(c) + CNT_W'(1)) << 1;
  endfunction

  // Width: doubling for codes 0..2, then 8 clocks per step
  function automatic logic [CNT_W-1:0] width_clks(input logic [CODE_W-1:0] c);
    if (c < CODE_W'(3)) return CNT_W'(2) << c;
    else                return (CNT_W'(c) - CNT_W'(1)) << 3;
  endfunction

endpackage

// File: rtl/tipclamp_cfg.sv
`timescale 1ns/1ps
module tipclamp_cfg
  import tipclamp_pkg::*;
#(
  parameter int          REG_W   = 8,
  parameter logic [7:0]  RST_VAL = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output clamp_cfg_t       cfg
);

  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_q <= REG_W'(RST_VAL);
    else if (we) reg_q <= wdata;
  end

  assign cfg = clamp_cfg_t'(reg_q);

endmodule

// File: rtl/tipclamp_timer.sv
`timescale 1ns/1ps
module tipclamp_timer
  import tipclamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_det,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] width_code,
  output logic              pulse
);

  tmr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wid_q;   // width captured at the accepted edge
  logic             sync_q;
  logic             sync_rise;

  assign sync_rise = sync_det & ~sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
      wid_q <= '0;
    end else begin
      unique case (st_q)
        TMR_IDLE: if (sync_rise) begin
          st_q  <= TMR_WAIT;
          cnt_q <= start_clks(start_code) - CNT_W'(1);
          wid_q <= width_clks(width_code);
        end
        TMR_WAIT: if (cnt_q == '0) begin
          st_q  <= TMR_HOLD;
          cnt_q <= wid_q - CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        TMR_HOLD: if (cnt_q == '0) begin
          st_q <= TMR_IDLE;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= TMR_IDLE;
      endcase
    end
  end

  assign pulse = (st_q == TMR_HOLD);

endmodule

// File: rtl/tipclamp_outmux.sv
`timescale 1ns/1ps
module tipclamp_outmux
  import tipclamp_pkg::*;
(
  input  pin_sel_e sel,
  input  logic     tip,
  input  logic     ped,
  input  logic     sync,
  output logic     pin_out,
  output logic     pin_oe
);

  always_comb begin
    pin_oe  = 1'b1;
    pin_out = 1'b0;
    unique case (sel)
      PIN_HIZ:  pin_oe  = 1'b0;
      PIN_TIP:  pin_out = tip;
      PIN_PED:  pin_out = ped;
      PIN_SYNC: pin_out = sync;
      default:  pin_oe  = 1'b0;
    endcase
  end

endmodule

// File: rtl/tipclamp_gen.sv
`timescale 1ns/1ps
module tipclamp_gen
  import tipclamp_pkg::*;
#(
  parameter int         REG_W   = 8,
  parameter logic [7:0] RST_VAL = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             sync_det,
  input  logic             ped_clamp,
  output logic             tip_pulse,
  output logic             pin_out,
  output logic             pin_oe
);

  clamp_cfg_t cfg;

  tipclamp_cfg #(.REG_W(REG_W), .RST_VAL(RST_VAL)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  tipclamp_timer u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_det   (sync_det),
    .start_code (cfg.start),
    .width_code (cfg.width),
    .pulse      (tip_pulse)
  );

  tipclamp_outmux u_mux (
    .sel     (cfg.sel),
    .tip     (tip_pulse),
    .ped     (ped_clamp),
    .sync    (sync_det),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  assign cfg_rdata = REG_W'(cfg);

endmodule

// File: rtl/tipclamp_chk.sv
`timescale 1ns/1ps
module tipclamp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       sync_det,
  input logic       ped_clamp,
  input logic       tip_pulse,
  input logic       pin_out,
  input logic       pin_oe
);

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tip_pulse) |-> !$past(tip_pulse, 2));

  // R4
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tip_pulse) |-> $past(tip_pulse, 2));

  // R7
  hiz_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] == 2'b00) |-> (!pin_oe && !pin_out));

  // R8
  tip_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] == 2'b01) |-> (pin_oe && pin_out == tip_pulse));

  // R9
  ped_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] == 2'b10) |-> (pin_oe && pin_out == ped_clamp));

  // R10
  sync_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] == 2'b11) |-> (pin_oe && pin_out == sync_det));

endmodule

bind tipclamp_gen tipclamp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .sync_det  (sync_det),
  .ped_clamp (ped_clamp),
  .tip_pulse (tip_pulse),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/tipclamp_gen_test.sv
`timescale 1ns/1ps
module tipclamp_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sync_det = 1'b0;
  logic       ped_clamp = 1'b0;
  logic       tip_pulse;
  logic       pin_out;
  logic       pin_oe;

  int checks = 0;
  int fails = 0;
  logic [7:0] cur_cfg = 8'h11;

  always #2.5 clk = ~clk;

  tipclamp_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sync_det(sync_det), .ped_clamp(ped_clamp),
    .tip_pulse(tip_pulse), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int exp_start(input logic [2:0] c);
    return 2 * (int'(c) + 1);
  endfunction

  function automatic int exp_width(input logic [2:0] c);
    case (c)
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;   3'd3: return 16;
      3'd4: return 24;  3'd5: return 32;  3'd6: return 40;  default: return 48;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v;
    chk("R2 readback", int'(cfg_rdata), int'(v));
  endtask

  // Fire one sync edge and measure the resulting pulse; inj_at / rew_at = 0 disables
  task automatic fire(input int d, input int w, input int inj_at,
                      input int rew_at, input logic [7:0] newval, input string tag);
    int first = -1;
    int highs = 0;
    int rises = 0;
    int pin_bad = 0;
    logic prev = 1'b0;
    for (int i = 0; i < 76; i++) begin
      @(negedge clk);
      ped_clamp = 1'($urandom);
      if (i == 0) sync_det = 1'b1;
      if (i == 2) sync_det = 1'b0;
      if (inj_at != 0 && i == inj_at) sync_det = 1'b1;
      if (inj_at != 0 && i == inj_at + 2) sync_det = 1'b0;
      if (rew_at != 0 && i == rew_at) begin cfg_we = 1'b1; cfg_wdata = newval; end
      if (rew_at != 0 && i == rew_at + 1) begin cfg_we = 1'b0; cur_cfg = newval; end
      @(posedge clk);
      #1;
      if (tip_pulse) begin
        highs++;
        if (first < 0) first = i;
      end
      if (tip_pulse && !prev) rises++;
      prev = tip_pulse;
      case (cur_cfg[7:6])
        2'b00: if (pin_oe || pin_out) pin_bad++;
        2'b01: if (!pin_oe || pin_out != tip_pulse) pin_bad++;
        2'b10: if (!pin_oe || pin_out != ped_clamp) pin_bad++;
        default: if (!pin_oe || pin_out != sync_det) pin_bad++;
      endcase
    end
    chk({"R3 start ", tag}, first, d);
    chk({"R4 width ", tag}, highs, w);
    chk({"R5 single pulse ", tag}, rises, 1);
    case (cur_cfg[7:6])
      2'b00: chk({"R7 pin hiz ", tag}, pin_bad, 0);
      2'b01: chk({"R8 pin tip ", tag}, pin_bad, 0);
      2'b10: chk({"R9 pin ped ", tag}, pin_bad, 0);
      default: chk({"R10 pin sync ", tag}, pin_bad, 0);
    endcase
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset reg", int'(cfg_rdata), 8'h11);
    chk("R1 reset oe", int'(pin_oe), 0);
    chk("R1 reset pulse", int'(tip_pulse), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 defaults drive the timer, R7 pin stays off
    fire(4, 8, 0, 0, 8'h00, "defaults");

    // Directed width table ends and step point
    write_cfg({2'b01, 3'd0, 3'd0});
    fire(2, 2, 0, 0, 8'h00, "min");
    write_cfg({2'b01, 3'd7, 3'd7});
    fire(16, 48, 0, 0, 8'h00, "max");
    write_cfg({2'b10, 3'd3, 3'd2});
    fire(6, 16, 0, 0, 8'h00, "code3");

    // R5 edge during pulse, then edge during delay
    write_cfg({2'b01, 3'd7, 3'd0});
    fire(2, 48, 4, 0, 8'h00, "edge in pulse");
    write_cfg({2'b11, 3'd0, 3'd7});
    fire(16, 2, 4, 0, 8'h00, "edge in delay");

    // R6 rewrite in the middle of a pulse, then the next edge uses it
    write_cfg({2'b01, 3'd5, 3'd1});
    fire(4, 32, 0, 8, {2'b01, 3'd0, 3'd0}, "rewrite mid pulse");
    chk("R6 reg after rewrite", int'(cfg_rdata), int'({2'b01, 3'd0, 3'd0}));
    fire(2, 2, 0, 0, 8'h00, "after rewrite");

    // Random configurations
    for (int n = 0; n < 40; n++) begin
      logic [7:0] v;
      v = 8'($urandom);
      write_cfg(v);
      fire(exp_start(v[2:0]), exp_width(v[5:3]), 0, 0, 8'h00, "random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule